// File: doc/BRIEF.md
# Wrapping Return-Address Stack

This block keeps the return addresses of a small processor core. Each call or interrupt entry pushes one entry (program counter plus status bits, 49 bits by default), and each return pops the most recent entry back out so the core can resume where it left off. The stack has a fixed depth of 16 entries and never reports overflow or underflow.

Storage is a ring of registers indexed by a wrapping top-of-stack pointer. Once more entries have been pushed than there are slots, the newest entry replaces the oldest one. The stack then always holds the most recent pushes. A pop on an empty stack is also defined: the pointer wraps backwards and the slot it lands on is read out. A push and a pop in the same cycle are not a legal request. If both strobes are high, only the push is carried out.

Top module: `rstk_top`

## Requirements
- R1: After reset, pop_valid_o and pop_data_o are 0 and the write pointer is at slot 0. The first push goes to slot 0, and a pop straight after it returns that data.
- R2: Pops return the pushed data in last-in-first-out order. This holds for any interleaving of pushes and pops.
- R3: A pop strobe without a push in the same cycle brings the popped entry out on pop_data_o and raises pop_valid_o in the next cycle. pop_valid_o is low in every cycle that does not follow such a pop.
- R4: The depth must be a power of two. After more than DEPTH pushes with no pop, only the newest DEPTH entries are kept, and they pop out in reverse order. Further pops keep going round the ring and return the newest entries again.
- R5: Reset clears the pointer and leaves the storage as it is. A pop made just after reset reads slot DEPTH-1 and leaves the pointer at DEPTH-1.
- R6: When push_i and pop_i are both high, the push is carried out and the pop is ignored. In that case pop_valid_o stays low in the next cycle and pop_data_o keeps its value.
- R7: pop_data_o holds the last popped value until the next effective pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_data_i | input | WIDTH (49) | Entry to save |
| pop_i | input | 1 | Pop strobe (return) |
| pop_data_o | output | WIDTH (49) | Last popped entry |
| pop_valid_o | output | 1 | High for one cycle after an effective pop |

## Verification
Pushes act at the clock edge that samples the strobe. Pop results pass through one register and appear in the cycle after the strobe edge. The bench drives its inputs on the falling edge and samples the outputs on the falling edge that follows the next rising edge, so every check lands exactly one register stage after its stimulus. A bench model of the ring predicts each popped value, the empty-stack read after reset, and the cycles where the push takes priority and the output must hold.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [1:0] {
        RSTK_IDLE = 2'd0,
        RSTK_PUSH = 2'd1,
        RSTK_POP  = 2'd2
    } rstk_op_e;

    // push has priority over pop (R6)
    function automatic rstk_op_e rstk_decode(input logic push, input logic pop);
        if (push)
            return RSTK_PUSH;
        else if (pop)
            return RSTK_POP;
        else
            return RSTK_IDLE;
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
    import rstk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rstk_op_e         op_i,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             pop_vld_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             vld;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (op_i)
            RSTK_PUSH: st_d.ptr = st_q.ptr + 1'b1;
            RSTK_POP: begin
                st_d.ptr = st_q.ptr - 1'b1;
                st_d.vld = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_idx_o  = st_q.ptr;
    assign rd_idx_o  = st_q.ptr - 1'b1;
    assign pop_vld_o = st_q.vld;

endmodule

// File: rtl/rstk_regfile.sv
module rstk_regfile #(
    parameter int WIDTH = 49,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             re_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] ent_d [DEPTH];
    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            ent_d[i] = ent_q[i];
        if (we_i)
            ent_d[waddr_i] = wdata_i;
        rd_d = re_i ? ent_q[raddr_i] : rd_q;
    end

    // storage is deliberately not reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++)
            ent_q[i] <= ent_d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int WIDTH = 49,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] pop_data_o,
    output logic             pop_valid_o
);

    localparam int PTR_W = $clog2(DEPTH);

    rstk_op_e         op;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;

    assign op = rstk_decode(push_i, pop_i);

    rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .wr_idx_o  (wr_idx),
        .rd_idx_o  (rd_idx),
        .pop_vld_o (pop_valid_o)
    );

    rstk_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (op == RSTK_PUSH),
        .waddr_i (wr_idx),
        .wdata_i (push_data_i),
        .re_i    (op == RSTK_POP),
        .raddr_i (rd_idx),
        .rdata_o (pop_data_o)
    );

endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
    parameter int WIDTH = 49
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic [WIDTH-1:0] push_data_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] pop_data_o,
    input logic             pop_valid_o
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !pop_valid_o && pop_data_o == '0);

    a_r3_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i |=> pop_valid_o);

    a_r6_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && pop_i |=> !pop_valid_o && $stable(pop_data_o));

    a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> !pop_valid_o && $stable(pop_data_o));

    a_r2_push_then_pop: assert property (@(posedge clk) disable iff (!rst_n)
        age_q >= 2'd2 && pop_i && !push_i && $past(push_i && !pop_i)
        |=> pop_data_o == $past(push_data_i, 2));

endmodule

bind rstk_top rstk_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o)
);

// File: tb/rstk_top_tb_top.sv
module rstk_top_tb_top;

    localparam int W = 49;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0;
    logic [W-1:0] push_data_i = '0;
    logic         pop_i = 1'b0;
    logic [W-1:0] pop_data_o;
    logic         pop_valid_o;

    int n_vec = 0;
    int n_err = 0;
    bit done = 1'b0;

    // bench model of the ring
    logic [W-1:0] m_ent [D];
    bit           m_known [D];
    int           m_ptr = 0;
    logic [W-1:0] m_data = '0;
    bit           m_data_known = 1'b1;

    always #4 clk = ~clk;  // 125 MHz

    rstk_top #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .pop_data_o  (pop_data_o),
        .pop_valid_o (pop_valid_o)
    );

    function automatic logic [W-1:0] rnd_word();
        return {$urandom(), $urandom()} & {W{1'b1}};
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s valid act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic check_word(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s data act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        push_i = 1'b0;
        pop_i  = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ptr = 0;
        m_data = '0;
        m_data_known = 1'b1;
        check_bit("R1", pop_valid_o, 1'b0);
        check_word("R1", pop_data_o, '0);
    endtask

    // one cycle: drive at falling edge, check one register stage later
    task automatic step(string req, bit ps, bit pp, logic [W-1:0] dat);
        bit exp_vld;
        push_i = ps;
        pop_i = pp;
        push_data_i = dat;
        exp_vld = 1'b0;
        if (ps) begin
            m_ent[m_ptr] = dat;
            m_known[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % D;
        end else if (pp) begin
            m_ptr = (m_ptr + D - 1) % D;
            m_data = m_ent[m_ptr];
            m_data_known = m_known[m_ptr];
            exp_vld = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        pop_i = 1'b0;
        check_bit(req, pop_valid_o, exp_vld);
        if (m_data_known)
            check_word(req, pop_data_o, m_data);
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin
            m_ent[i] = '0;
            m_known[i] = 1'b0;
        end
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R1 / R2: single push then pop
        step("R1", 1, 0, 49'h1_2345_6789_ABCD);
        step("R1", 0, 1, '0);
        // R2: short LIFO sequence
        for (int i = 0; i < 5; i++) step("R2", 1, 0, rnd_word());
        for (int i = 0; i < 5; i++) step("R2", 0, 1, '0);
        // R4: overflow by four, then pop round the ring more than once
        for (int i = 0; i < D + 4; i++) step("R4", 1, 0, W'(64'h100 + i));
        for (int i = 0; i < D + 6; i++) step("R4", 0, 1, '0);
        // R6: both strobes high
        step("R6", 1, 0, rnd_word());
        step("R6", 0, 1, '0);
        step("R6", 1, 1, rnd_word());
        step("R6", 0, 1, '0);
        // R7: idle cycles hold the value
        for (int i = 0; i < 3; i++) step("R7", 0, 0, rnd_word());
        // R5: fill every slot, reset, pop reads slot D-1
        for (int i = 0; i < D; i++) step("R5", 1, 0, W'(64'hA000 + i));
        do_reset();
        step("R5", 0, 1, '0);
        step("R5", 0, 1, '0);
        step("R5", 1, 0, rnd_word());
        step("R5", 0, 1, '0);

        // R2/R3/R6/R7 random mix
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            bit ps = (r < 45) || (r >= 95);
            bit pp = (r >= 45 && r < 85) || (r >= 95);
            step("R3", ps, pp, rnd_word());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule